// File: doc/BRIEF.md
# Saturating Semaphore Cell

A single 16-bit counting semaphore for synchronizing hardware threads. Each thread reaches the cell through one shared request port that carries a valid strobe, a write flag, a two-bit view code, a thread id and write data. Every accepted request gets a registered response one cycle later. The response carries the thread id, the read data and a stall flag.

The view code selects how the access behaves. The bypass view reads or overwrites the raw count. The control view reads or writes the cell tag. The two counting views treat a load as "take one" and a store as "give one". A load returns the count and then lowers it, but never below zero. A store raises the count by exactly one and stops at the top value. In the synchronized view, a load that finds zero parks the thread in a waiter bitmap. In the try view, the same load simply returns zero. A later counting store releases the lowest-numbered waiter, and that release is reported on a separate wake output.

Top module: `sema_cell`

## Requirements
- R1: After reset the count is 0, the waiter bitmap is all clear, and the tag's empty and full bits are both 0.
- R2: A load in the synchronized view (view 2'b10) or the try view (view 2'b11) with a nonzero count returns that count in rsp_data with rsp_stall low, and leaves count-1 in the cell.
- R3: A store in view 2'b10 or 2'b11 with no waiters adds exactly one to the count, whatever req_wdata holds. At 0xFFFF the count stays at 0xFFFF. The write response returns rsp_data 0.
- R4: A load in view 2'b10 that finds a zero count answers with rsp_stall high and rsp_data 0. It sets bit req_tid of `waiters` and leaves the count at 0.
- R5: A load in view 2'b11 that finds a zero count answers with rsp_stall low and rsp_data 0. It leaves the count at 0 and the bitmap unchanged.
- R6: A store in view 2'b10 or 2'b11 while `waiters` is nonzero releases the lowest-numbered waiter on the next cycle. The release raises wake_valid, puts that thread id on wake_tid, and puts the saturated incremented count on wake_data. It clears that waiter's bit and leaves wake_data-1 in the cell.
- R7: In the bypass view (2'b00), a load returns the count unchanged. A store sets the count to req_wdata. Neither one touches the bitmap or the tag bits.
- R8: In the control view (2'b01), a load returns the tag with empty in bit 0, full in bit 1, the FIFO-type bit 2 reading 0, and all other bits 0. A store loads empty and full from req_wdata bits 0 and 1. Accesses in any other view leave both bits unchanged.
- R9: Every request with req_valid high gets rsp_valid high on the next cycle, with rsp_tid equal to its req_tid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 = store, 0 = load |
| req_view | input | 2 | 00 bypass, 01 control, 10 synchronized, 11 try |
| req_tid | input | TID_W (2) | Requesting thread |
| req_wdata | input | CNT_W (16) | Store data |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_tid | output | TID_W (2) | Thread being answered |
| rsp_data | output | CNT_W (16) | Load result |
| rsp_stall | output | 1 | Thread has been parked |
| wake_valid | output | 1 | A parked thread is released |
| wake_tid | output | TID_W (2) | Released thread |
| wake_data | output | CNT_W (16) | Value handed to the released thread |
| waiters | output | THREADS (4) | Bitmap of parked threads |

## Verification
The hardest case to reach is a release at the top of the range: several threads parked while the count sits at 0xFFFF. Parking only happens at zero, so the bench first parks threads in a non-sorted order. It then raises the count through the bypass view without releasing anyone, and then issues counting stores. Each store must release exactly the lowest remaining waiter, with saturated data. Sweeps of up-counts and down-counts through zero, and of all tag patterns, cover the remaining behaviour against an arithmetic model in the bench.

// File: rtl/sema_cell.sv
module sema_cell #(
  parameter int CNT_W   = 16,
  parameter int THREADS = 4,
  localparam int TID_W  = (THREADS > 1) ? $clog2(THREADS) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic               req_write,
  input  logic [1:0]         req_view,
  input  logic [TID_W-1:0]   req_tid,
  input  logic [CNT_W-1:0]   req_wdata,
  output logic               rsp_valid,
  output logic [TID_W-1:0]   rsp_tid,
  output logic [CNT_W-1:0]   rsp_data,
  output logic               rsp_stall,
  output logic               wake_valid,
  output logic [TID_W-1:0]   wake_tid,
  output logic [CNT_W-1:0]   wake_data,
  output logic [THREADS-1:0] waiters
);
  localparam logic [CNT_W-1:0] TOP = '1;

  logic [CNT_W-1:0] count;
  logic             tag_empty, tag_full;
  logic [TID_W-1:0] low_tid;

  wire              counting = req_view[1];
  wire              any_wait = |waiters;
  wire [CNT_W-1:0]  cnt_inc  = (count == TOP) ? count : count + 1'b1;

  always_comb begin
    low_tid = '0;
    for (int i = THREADS - 1; i >= 0; i--)
      if (waiters[i]) low_tid = TID_W'(i);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count      <= '0;
      waiters    <= '0;
      tag_empty  <= 1'b0;
      tag_full   <= 1'b0;
      rsp_valid  <= 1'b0;
      rsp_tid    <= '0;
      rsp_data   <= '0;
      rsp_stall  <= 1'b0;
      wake_valid <= 1'b0;
      wake_tid   <= '0;
      wake_data  <= '0;
    end else begin
      rsp_valid  <= req_valid;
      wake_valid <= 1'b0;
      if (req_valid) begin
        rsp_tid   <= req_tid;
        rsp_stall <= 1'b0;
        rsp_data  <= '0;
        if (!counting) begin
          if (req_view[0]) begin
            if (req_write) {tag_full, tag_empty} <= req_wdata[1:0];
            else rsp_data <= {{(CNT_W-3){1'b0}}, 1'b0, tag_full, tag_empty};
          end else begin
            if (req_write) count <= req_wdata;
            else rsp_data <= count;
          end
        end else if (req_write) begin
          if (any_wait) begin
            waiters[low_tid] <= 1'b0;
            wake_valid       <= 1'b1;
            wake_tid         <= low_tid;
            wake_data        <= cnt_inc;
            count            <= cnt_inc - 1'b1;
          end else begin
            count <= cnt_inc;
          end
        end else if (count != '0) begin
          rsp_data <= count;
          count    <= count - 1'b1;
        end else if (!req_view[0]) begin
          rsp_stall        <= 1'b1;
          waiters[req_tid] <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/sema_cell_chk.sv
module sema_cell_chk #(
  parameter int CNT_W   = 16,
  parameter int THREADS = 4,
  localparam int TID_W  = (THREADS > 1) ? $clog2(THREADS) : 1
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic               req_write,
  input logic [1:0]         req_view,
  input logic [TID_W-1:0]   req_tid,
  input logic               rsp_valid,
  input logic [TID_W-1:0]   rsp_tid,
  input logic               rsp_stall,
  input logic [CNT_W-1:0]   rsp_data,
  input logic               wake_valid,
  input logic [THREADS-1:0] waiters,
  input logic [CNT_W-1:0]   count
);
  localparam logic [CNT_W-1:0] TOP = '1;

  assert_load_decrements_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && req_view[1] && count != '0)
      |=> (count == $past(count) - 1'b1) && rsp_data == $past(count));

  assert_store_saturates_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && req_view[1] && count == TOP && waiters == '0)
      |=> count == TOP);

  assert_sync_zero_parks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && req_view == 2'b10 && count == '0)
      |=> rsp_stall && waiters[$past(req_tid)]);

  assert_try_zero_no_stall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && req_view == 2'b11 && count == '0)
      |=> !rsp_stall && rsp_data == '0 && $stable(waiters));

  assert_wake_clears_one_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wake_valid |-> $countones(waiters) == $countones($past(waiters)) - 1);

  assert_response_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid && rsp_tid == $past(req_tid));
endmodule

bind sema_cell sema_cell_chk #(.CNT_W(CNT_W), .THREADS(THREADS)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .req_view(req_view), .req_tid(req_tid), .rsp_valid(rsp_valid),
  .rsp_tid(rsp_tid), .rsp_stall(rsp_stall), .rsp_data(rsp_data),
  .wake_valid(wake_valid), .waiters(waiters), .count(count)
);

// File: tb/sim_sema_cell.sv
module sim_sema_cell;
  localparam int PERIOD = 10;

  logic        clk = 0, rst_n = 0;
  logic        req_valid = 0, req_write = 0;
  logic [1:0]  req_view = 0;
  logic [1:0]  req_tid = 0;
  logic [15:0] req_wdata = 0;
  logic        rsp_valid, rsp_stall, wake_valid;
  logic [1:0]  rsp_tid, wake_tid;
  logic [15:0] rsp_data, wake_data;
  logic [3:0]  waiters;

  int total = 0, bad = 0;
  int m_cnt = 0;
  logic [3:0] m_wait = 0;
  logic m_empty = 0, m_full = 0;

  always #(PERIOD/2) clk = ~clk;

  sema_cell u0 (.*);

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic access(input string req, input bit wr, input int view, input int tid, input int data);
    int e_data = 0, e_wtid = 0, e_wdat = 0;
    bit e_stall = 0, e_wake = 0;
    case (view)
      0: if (wr) m_cnt = data; else e_data = m_cnt;
      1: if (wr) begin m_empty = data[0]; m_full = data[1]; end
         else e_data = m_full * 2 + m_empty;
      default: begin
        if (wr) begin
          int inc = (m_cnt == 16'hFFFF) ? m_cnt : m_cnt + 1;
          if (m_wait != 0) begin
            int w = 0;
            while (!m_wait[w]) w++;
            m_wait[w] = 0; e_wake = 1; e_wtid = w; e_wdat = inc; m_cnt = inc - 1;
          end else m_cnt = inc;
        end else if (m_cnt != 0) begin
          e_data = m_cnt; m_cnt--;
        end else if (view == 2) begin
          e_stall = 1; m_wait[tid] = 1;
        end
      end
    endcase
    @(negedge clk);
    req_valid = 1; req_write = wr; req_view = view[1:0];
    req_tid = tid[1:0]; req_wdata = data[15:0];
    @(negedge clk);
    req_valid = 0;
    chk(req, "rsp_valid (R9)", rsp_valid, 1);
    chk(req, "rsp_tid (R9)", rsp_tid, tid);
    chk(req, "rsp_data", rsp_data, e_data);
    chk(req, "rsp_stall", rsp_stall, e_stall);
    chk(req, "waiters", waiters, m_wait);
    chk(req, "wake_valid", wake_valid, e_wake);
    if (e_wake) begin
      chk(req, "wake_tid", wake_tid, e_wtid);
      chk(req, "wake_data", wake_data, e_wdat);
    end
  endtask

  task automatic peek(input string req);
    access(req, 0, 0, 0, 0);
  endtask

  initial begin
    #(PERIOD * 200000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1", "rsp_valid", rsp_valid, 0);
    chk("R1", "waiters", waiters, 0);
    peek("R1");
    access("R1", 0, 1, 0, 0);

    for (int i = 0; i < 40; i++) access("R3", 1, 2 + (i % 2), i % 4, i * 4099);
    peek("R3");
    for (int i = 0; i < 44; i++) access("R2", 0, 3, (i * 3) % 4, 0);
    peek("R5");
    for (int i = 0; i < 6; i++) begin
      access("R3", 1, 3, 1, 16'hFFFF);
      access("R2", 0, 2, 2, 0);
      access("R5", 0, 3, 3, 0);
    end

    access("R7", 1, 0, 0, 16'hFFFD);
    for (int i = 0; i < 4; i++) access("R3", 1, 2, i, 0);
    peek("R3");
    access("R2", 0, 2, 0, 0);

    access("R7", 1, 0, 0, 0);
    access("R4", 0, 2, 3, 0);
    access("R4", 0, 2, 1, 0);
    access("R4", 0, 2, 2, 0);
    access("R5", 0, 3, 0, 0);
    access("R7", 1, 0, 1, 16'hFFFF);
    peek("R7");
    access("R6", 1, 3, 0, 0);
    access("R6", 1, 2, 0, 0);
    peek("R6");
    access("R7", 1, 0, 0, 0);
    access("R6", 1, 2, 0, 16'h1234);
    peek("R6");
    access("R3", 1, 2, 0, 0);
    peek("R3");

    for (int i = 0; i < 4; i++) begin
      access("R8", 1, 1, i, 16'hFFF0 | i);
      access("R8", 0, 1, i, 0);
      access("R8", 1, 2, i, 0);
      access("R8", 0, 3, i, 0);
      access("R8", 1, 0, i, i * 5);
      access("R8", 0, 1, i, 0);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule